// File: doc/BRIEF.md
# Receive Buffer Auto-DMA Switch Controller

This block sits between a receive MAC and an on-chip frame buffer and decides, for every arriving frame, whether to store it on chip, drop it, or put reception into DMA mode so that stored frames drain to host memory. It keeps its own bookkeeping of the frames held in the buffer: a descriptor queue of start offsets and lengths, in arrival order, plus a count of occupied bytes in a ring of `2**ADDR_W` bytes.

Two configuration bits select the policy. With `cfg_dma_only` set, every frame goes to host memory. With `cfg_auto` set, frames are stored normally until one does not fit. A frame that passes the address filter then starts an automatic switch, and the oldest stored frames drain one whole frame at a time until the waiting frame fits. While the host owns (has committed) the oldest frame, the block neither switches nor issues DMA requests. Each finished transfer updates the DMA status registers and can raise an interrupt.

Arrivals use valid/ready. `arr_valid` with its `arr_da_pass` and `arr_len` must stay stable until `arr_ready` is seen high at a clock edge. A low `arr_ready` means the frame is held until space frees or the host releases its commit. DMA requests also use valid/ready: a request stays offered until `dma_req_ready` takes it, and `dma_done` later marks the end of that frame's transfer.

Top module: `rxd_autodma`

## Requirements
- R1: With `cfg_dma_only` high, no frame of length up to the capacity is dropped. Each accepted frame gets result code 2'b01 (stored) and is then offered on the DMA request port.
- R2: With both `cfg_dma_only` and `cfg_auto` low, a frame that fits is stored (code 2'b01) and one that does not fit is dropped (code 2'b10). `dma_req_valid` stays low.
- R3: With `cfg_auto` high and enough free space, the frame is stored with no DMA request and no `isq_flush`.
- R4: With `cfg_auto` high, too little space and `arr_da_pass` low, the frame is dropped (code 2'b10) in the cycle it is offered.
- R5: With `cfg_auto` high, too little space, `arr_da_pass` high, no commit and a non-empty queue, the frame is held (`arr_ready` low). DMA mode starts on the next clock edge, and `isq_flush` goes high for exactly one cycle.
- R6: DMA requests carry the start offset and length of the oldest stored frame, and frames leave in arrival order.
- R7: Requests are whole frames, `dma_req_len` is the full stored length, and no new request is offered between an accepted request and its `dma_done`.
- R8: While `host_commit` is high, no automatic switch starts and `dma_req_valid` stays low.
- R9: Space held by a frame in transfer becomes free only at `dma_done`, and a held frame that then fits is accepted in the next cycle.
- R10: At `dma_done`, `stat_sof` and `stat_bytes` take the finished frame's offset and length and `stat_dma_frame` is set. `irq` is high exactly when `stat_dma_frame` and `cfg_irq_en` are both high.
- R11: `stat_frame_cnt` counts the frames finished since the last `stat_rd` pulse. That pulse clears both the count and `stat_dma_frame`.
- R12: A frame longer than the capacity is always dropped. A full descriptor queue counts as too little space.
- R13: An automatic DMA mode ends once the queue is empty, and later frames that fit are stored without DMA requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dma_only | input | 1 | Send every frame to host memory |
| cfg_auto | input | 1 | Enable automatic switch on lack of space |
| cfg_irq_en | input | 1 | Interrupt enable for finished DMA frames |
| arr_valid | input | 1 | Frame arrival offered |
| arr_ready | output | 1 | Arrival decided this cycle |
| arr_da_pass | input | 1 | Destination-address filter passed |
| arr_len | input | ADDR_W+1 | Frame length in bytes (at least 1) |
| res_valid | output | 1 | Decision result valid (one cycle after acceptance) |
| res_code | output | 2 | 2'b01 stored, 2'b10 dropped |
| host_commit | input | 1 | Host owns the oldest stored frame |
| host_pop | input | 1 | Host has read or skipped the oldest frame |
| dma_req_valid | output | 1 | Whole-frame DMA request offered |
| dma_req_ready | input | 1 | DMA engine takes the request |
| dma_req_sof | output | ADDR_W | Buffer offset of the requested frame |
| dma_req_len | output | ADDR_W+1 | Length of the requested frame |
| dma_done | input | 1 | Transfer of the accepted request finished |
| isq_flush | output | 1 | Discard pending receive-event reports |
| stat_rd | input | 1 | Host reads the DMA status |
| stat_dma_frame | output | 1 | A DMA frame finished since the last read |
| stat_sof | output | ADDR_W | Offset of the last finished DMA frame |
| stat_bytes | output | ADDR_W+1 | Length of the last finished DMA frame |
| stat_frame_cnt | output | CNT_W | Frames finished since the last read |
| irq | output | 1 | Interrupt |

## Verification
The assertions take several things for granted about the inputs. `dma_done` arrives only while an accepted request is in flight. `host_pop` never coincides with a transfer. `host_commit` is not raised while a frame is in transfer. The arrival fields stay stable while `arr_ready` is low. The stimulus holds each offered frame unchanged until it is taken, and pulses `dma_done` only after it has seen a request accepted. It releases the host commit only in a cycle after its pop, and issues `stat_rd` only in cycles without a completion.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_BUF  = 2'b01,
    RES_DROP = 2'b10
  } res_e;
endpackage

// File: rtl/rxd_desc_fifo.sv
module rxd_desc_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 12,
  parameter int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_sof,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic [AW-1:0] head_sof,
  output logic [LW-1:0] head_len,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [AW-1:0] sof_mem [DEPTH];
  logic [LW-1:0] len_mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign head_sof = sof_mem[rd_ptr];
  assign head_len = len_mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sof_mem[i] <= '0;
        len_mem[i] <= '0;
      end else if (push && !full && wr_ptr == PW'(i)) begin
        sof_mem[i] <= push_sof;
        len_mem[i] <= push_len;
      end
    end
  end
endmodule

// File: rtl/rxd_space_acct.sv
module rxd_space_acct #(
  parameter int AW = 12,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [LW-1:0] alloc_len,
  input  logic          release_en,
  input  logic [LW-1:0] release_len,
  output logic [AW-1:0] wr_off,
  output logic [LW-1:0] free_bytes
);
  localparam logic [LW-1:0] CAP = {1'b1, {AW{1'b0}}};

  logic [LW-1:0] used;

  assign free_bytes = CAP - used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used   <= '0;
      wr_off <= '0;
    end else begin
      if (alloc) wr_off <= wr_off + alloc_len[AW-1:0];
      case ({alloc, release_en})
        2'b10:   used <= used + alloc_len;
        2'b01:   used <= used - release_len;
        2'b11:   used <= used + alloc_len - release_len;
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/rxd_switch_ctrl.sv
module rxd_switch_ctrl #(
  parameter int AW = 12,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dma_only,
  input  logic          cfg_auto,
  input  logic          arr_valid,
  input  logic          arr_da_pass,
  input  logic [LW-1:0] arr_len,
  input  logic [LW-1:0] free_bytes,
  input  logic          q_full,
  input  logic          q_empty,
  input  logic          host_commit,
  output logic          arr_ready,
  output logic          take_buf,
  output logic          take_drop,
  output logic          mode_dma,
  output logic          auto_on,
  output logic          isq_flush
);
  localparam logic [LW-1:0] CAP = {1'b1, {AW{1'b0}}};

  logic too_big, fits, wait_space, trigger, auto_q, mode_prev_q;

  assign too_big = (arr_len > CAP);
  assign fits    = !too_big && !q_full && (arr_len <= free_bytes);

  always_comb begin
    wait_space = 1'b0;
    take_drop  = 1'b0;
    if (too_big) begin
      take_drop = 1'b1;
    end else if (!fits) begin
      if (cfg_dma_only)                wait_space = 1'b1;
      else if (cfg_auto || auto_q)     wait_space = arr_da_pass;
      else                             wait_space = 1'b0;
      take_drop = !wait_space;
    end
  end

  assign take_buf  = fits;
  assign arr_ready = take_buf | take_drop;

  assign trigger = arr_valid && !fits && !too_big && !cfg_dma_only &&
                   cfg_auto && arr_da_pass && !auto_q && !q_empty && !host_commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q      <= 1'b0;
      mode_prev_q <= 1'b0;
    end else begin
      if (trigger)      auto_q <= 1'b1;
      else if (q_empty) auto_q <= 1'b0;
      mode_prev_q <= mode_dma;
    end
  end

  assign auto_on   = auto_q;
  assign mode_dma  = cfg_dma_only | auto_q;
  assign isq_flush = mode_dma & ~mode_prev_q;
endmodule

// File: rtl/rxd_dma_status.sv
module rxd_dma_status #(
  parameter int AW    = 12,
  parameter int LW    = AW + 1,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_dma,
  input  logic             q_empty,
  input  logic             host_commit,
  input  logic [AW-1:0]    head_sof,
  input  logic [LW-1:0]    head_len,
  input  logic             dma_req_ready,
  input  logic             dma_done,
  input  logic             stat_rd,
  input  logic             cfg_irq_en,
  output logic             dma_req_valid,
  output logic [AW-1:0]    dma_req_sof,
  output logic [LW-1:0]    dma_req_len,
  output logic             inflight,
  output logic             frame_out,
  output logic             stat_dma_frame,
  output logic [AW-1:0]    stat_sof,
  output logic [LW-1:0]    stat_bytes,
  output logic [CNT_W-1:0] stat_frame_cnt,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic inflight_q;

  assign inflight      = inflight_q;
  assign dma_req_valid = mode_dma && !q_empty && !host_commit && !inflight_q;
  assign dma_req_sof   = head_sof;
  assign dma_req_len   = head_len;
  assign frame_out     = dma_done && inflight_q;
  assign irq           = stat_dma_frame && cfg_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q     <= 1'b0;
      stat_dma_frame <= 1'b0;
      stat_sof       <= '0;
      stat_bytes     <= '0;
      stat_frame_cnt <= '0;
    end else begin
      if (dma_req_valid && dma_req_ready) inflight_q <= 1'b1;
      else if (frame_out)                 inflight_q <= 1'b0;

      if (frame_out) begin
        stat_sof       <= head_sof;
        stat_bytes     <= head_len;
        stat_dma_frame <= 1'b1;
        if (stat_rd)                       stat_frame_cnt <= CNT_W'(1);
        else if (stat_frame_cnt != CNT_MAX) stat_frame_cnt <= stat_frame_cnt + 1'b1;
      end else if (stat_rd) begin
        stat_dma_frame <= 1'b0;
        stat_frame_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/rxd_autodma.sv
module rxd_autodma
  import rxd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int QDEPTH = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dma_only,
  input  logic              cfg_auto,
  input  logic              cfg_irq_en,
  input  logic              arr_valid,
  output logic              arr_ready,
  input  logic              arr_da_pass,
  input  logic [ADDR_W:0]   arr_len,
  output logic              res_valid,
  output logic [1:0]        res_code,
  input  logic              host_commit,
  input  logic              host_pop,
  output logic              dma_req_valid,
  input  logic              dma_req_ready,
  output logic [ADDR_W-1:0] dma_req_sof,
  output logic [ADDR_W:0]   dma_req_len,
  input  logic              dma_done,
  output logic              isq_flush,
  input  logic              stat_rd,
  output logic              stat_dma_frame,
  output logic [ADDR_W-1:0] stat_sof,
  output logic [ADDR_W:0]   stat_bytes,
  output logic [CNT_W-1:0]  stat_frame_cnt,
  output logic              irq
);
  localparam int LW = ADDR_W + 1;

  logic              take_buf, take_drop, mode_dma, auto_on;
  logic              q_empty, q_full, inflight, frame_out;
  logic              push, pop;
  logic [ADDR_W-1:0] head_sof, wr_off;
  logic [LW-1:0]     head_len, free_bytes;

  assign push = arr_valid && take_buf;
  assign pop  = frame_out || (host_pop && !inflight && !q_empty);

  rxd_switch_ctrl #(.AW(ADDR_W), .LW(LW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_dma_only(cfg_dma_only),
    .cfg_auto    (cfg_auto),
    .arr_valid   (arr_valid),
    .arr_da_pass (arr_da_pass),
    .arr_len     (arr_len),
    .free_bytes  (free_bytes),
    .q_full      (q_full),
    .q_empty     (q_empty),
    .host_commit (host_commit),
    .arr_ready   (arr_ready),
    .take_buf    (take_buf),
    .take_drop   (take_drop),
    .mode_dma    (mode_dma),
    .auto_on     (auto_on),
    .isq_flush   (isq_flush)
  );

  rxd_desc_fifo #(.DEPTH(QDEPTH), .AW(ADDR_W), .LW(LW)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .push_sof(wr_off),
    .push_len(arr_len),
    .pop     (pop),
    .head_sof(head_sof),
    .head_len(head_len),
    .empty   (q_empty),
    .full    (q_full)
  );

  rxd_space_acct #(.AW(ADDR_W), .LW(LW)) u_space (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (push),
    .alloc_len  (arr_len),
    .release_en (pop),
    .release_len(head_len),
    .wr_off     (wr_off),
    .free_bytes (free_bytes)
  );

  rxd_dma_status #(.AW(ADDR_W), .LW(LW), .CNT_W(CNT_W)) u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_dma      (mode_dma),
    .q_empty       (q_empty),
    .host_commit   (host_commit),
    .head_sof      (head_sof),
    .head_len      (head_len),
    .dma_req_ready (dma_req_ready),
    .dma_done      (dma_done),
    .stat_rd       (stat_rd),
    .cfg_irq_en    (cfg_irq_en),
    .dma_req_valid (dma_req_valid),
    .dma_req_sof   (dma_req_sof),
    .dma_req_len   (dma_req_len),
    .inflight      (inflight),
    .frame_out     (frame_out),
    .stat_dma_frame(stat_dma_frame),
    .stat_sof      (stat_sof),
    .stat_bytes    (stat_bytes),
    .stat_frame_cnt(stat_frame_cnt),
    .irq           (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= RES_NONE;
    end else begin
      res_valid <= arr_valid && arr_ready;
      if (arr_valid && arr_ready) res_code <= take_buf ? RES_BUF : RES_DROP;
    end
  end
endmodule

// File: rtl/rxd_autodma_chk.sv
module rxd_autodma_chk #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_dma_only,
  input logic             cfg_auto,
  input logic             arr_valid,
  input logic             arr_ready,
  input logic [ADDR_W:0]  arr_len,
  input logic             res_valid,
  input logic [1:0]       res_code,
  input logic             host_commit,
  input logic             dma_req_valid,
  input logic             dma_req_ready,
  input logic             dma_done,
  input logic             isq_flush,
  input logic             stat_rd,
  input logic             stat_dma_frame,
  input logic [CNT_W-1:0] stat_frame_cnt,
  input logic             auto_on
);
  localparam logic [ADDR_W:0] CAP = {1'b1, {ADDR_W{1'b0}}};

  a_r2_no_dma_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dma_only && !auto_on) |-> !dma_req_valid);

  a_r8_commit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    host_commit |-> !dma_req_valid);

  a_r5_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    isq_flush |=> !isq_flush);

  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && dma_req_ready) |=> !dma_req_valid);

  a_r12_too_big_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && arr_len > CAP) |=> (res_valid && res_code == 2'b10));

  a_r1_dma_only_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && arr_ready && cfg_dma_only && arr_len <= CAP) |=> (res_code == 2'b01));

  a_r10_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> stat_dma_frame);

  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !dma_done) |=> (!stat_dma_frame && stat_frame_cnt == '0));
endmodule

bind rxd_autodma rxd_autodma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_dma_only  (cfg_dma_only),
  .cfg_auto      (cfg_auto),
  .arr_valid     (arr_valid),
  .arr_ready     (arr_ready),
  .arr_len       (arr_len),
  .res_valid     (res_valid),
  .res_code      (res_code),
  .host_commit   (host_commit),
  .dma_req_valid (dma_req_valid),
  .dma_req_ready (dma_req_ready),
  .dma_done      (dma_done),
  .isq_flush     (isq_flush),
  .stat_rd       (stat_rd),
  .stat_dma_frame(stat_dma_frame),
  .stat_frame_cnt(stat_frame_cnt),
  .auto_on       (auto_on)
);

// File: tb/rxd_autodma_tb.sv
module rxd_autodma_tb;
  localparam int AW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_dma_only = 0, cfg_auto = 0, cfg_irq_en = 0;
  logic          arr_valid = 0, arr_da_pass = 0;
  logic [AW:0]   arr_len = '0;
  logic          arr_ready, res_valid;
  logic [1:0]    res_code;
  logic          host_commit = 0, host_pop = 0;
  logic          dma_req_valid, dma_req_ready = 0, dma_done = 0;
  logic [AW-1:0] dma_req_sof, stat_sof;
  logic [AW:0]   dma_req_len, stat_bytes;
  logic          isq_flush, stat_rd = 0, stat_dma_frame, irq;
  logic [CW-1:0] stat_frame_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rxd_autodma #(.ADDR_W(AW), .QDEPTH(4), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dma_only(cfg_dma_only), .cfg_auto(cfg_auto),
    .cfg_irq_en(cfg_irq_en), .arr_valid(arr_valid), .arr_ready(arr_ready),
    .arr_da_pass(arr_da_pass), .arr_len(arr_len), .res_valid(res_valid),
    .res_code(res_code), .host_commit(host_commit), .host_pop(host_pop),
    .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
    .dma_req_sof(dma_req_sof), .dma_req_len(dma_req_len), .dma_done(dma_done),
    .isq_flush(isq_flush), .stat_rd(stat_rd), .stat_dma_frame(stat_dma_frame),
    .stat_sof(stat_sof), .stat_bytes(stat_bytes), .stat_frame_cnt(stat_frame_cnt),
    .irq(irq)
  );

  // vector: pop_first, dma_only, auto, da_pass, len[8:0], expected code[1:0]
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 9'd100, 2'b01},  // R2 fits
    {1'b0, 1'b0, 1'b0, 1'b1, 9'd100, 2'b01},  // R2 fits
    {1'b0, 1'b0, 1'b0, 1'b1, 9'd100, 2'b10},  // R2 no space, DMA off
    {1'b0, 1'b0, 1'b1, 1'b1, 9'd50,  2'b01},  // R3 auto, fits
    {1'b0, 1'b0, 1'b1, 1'b0, 9'd20,  2'b10},  // R4 auto, no space, filter fails
    {1'b0, 1'b0, 1'b0, 1'b1, 9'd300, 2'b10},  // R12 longer than capacity
    {1'b1, 1'b0, 1'b0, 1'b1, 9'd100, 2'b01},  // R2 after host pop
    {1'b1, 1'b0, 1'b0, 1'b1, 9'd6,   2'b01},  // R2 after host pop
    {1'b0, 1'b0, 1'b0, 1'b1, 9'd1,   2'b01},  // R2 fills queue
    {1'b0, 1'b0, 1'b0, 1'b1, 9'd1,   2'b10}   // R12 queue full
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {cfg_dma_only, cfg_auto, cfg_irq_en, arr_valid, host_commit, host_pop} = '0;
    {dma_req_ready, dma_done, stat_rd} = '0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic store(input int len);
    arr_valid = 1; arr_da_pass = 1; arr_len = (AW+1)'(len);
    tick();
    arr_valid = 0;
  endtask

  task automatic take_and_finish();
    dma_req_ready = 1;
    tick();
    dma_req_ready = 0;
    tick();
    dma_done = 1;
    tick();
    dma_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // reset state
    chk(dma_req_valid == 0, "reset", int'(dma_req_valid), 0);
    chk(stat_dma_frame == 0 && stat_frame_cnt == 0, "reset R11", int'(stat_frame_cnt), 0);
    chk(irq == 0 && isq_flush == 0 && res_valid == 0, "reset R10", int'(irq), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][14]) begin
        host_pop = 1;
        tick();
        host_pop = 0;
      end
      cfg_dma_only = VEC[i][13];
      cfg_auto     = VEC[i][12];
      arr_da_pass  = VEC[i][11];
      arr_len      = VEC[i][10:2];
      arr_valid    = 1;
      #1;
      chk(arr_ready == 1, "R2 immediate decision", int'(arr_ready), 1);
      tick();
      arr_valid = 0;
      chk(res_valid == 1 && res_code == VEC[i][1:0], "R2 R3 R4 R12 result",
          int'(res_code), int'(VEC[i][1:0]));
      chk(dma_req_valid == 0 && isq_flush == 0, "R3 no DMA", int'(dma_req_valid), 0);
    end

    // automatic switch, ordering, release timing, status
    do_reset();
    cfg_irq_en = 1;
    store(100);
    store(100);
    cfg_auto = 1; arr_da_pass = 1; arr_len = 9'd100; arr_valid = 1;
    #1;
    chk(arr_ready == 0, "R5 held", int'(arr_ready), 0);
    tick();
    chk(isq_flush == 1, "R5 flush", int'(isq_flush), 1);
    chk(dma_req_valid == 1 && dma_req_sof == 0, "R6 oldest first", int'(dma_req_sof), 0);
    chk(dma_req_len == 100, "R7 whole frame", int'(dma_req_len), 100);
    tick();
    chk(isq_flush == 0, "R5 single pulse", int'(isq_flush), 0);
    dma_req_ready = 1;
    tick();
    dma_req_ready = 0;
    chk(dma_req_valid == 0, "R7 one outstanding", int'(dma_req_valid), 0);
    tick();
    chk(arr_ready == 0, "R9 not freed before done", int'(arr_ready), 0);
    dma_done = 1;
    tick();
    dma_done = 0;
    chk(stat_dma_frame == 1 && irq == 1, "R10 status and irq", int'(irq), 1);
    chk(stat_sof == 0 && stat_bytes == 100, "R10 registers", int'(stat_bytes), 100);
    chk(stat_frame_cnt == 1, "R11 count", int'(stat_frame_cnt), 1);
    chk(arr_ready == 1, "R9 freed at done", int'(arr_ready), 1);
    tick();
    arr_valid = 0;
    chk(res_valid == 1 && res_code == 2'b01, "R9 held frame stored", int'(res_code), 1);
    chk(dma_req_valid == 1 && dma_req_sof == 100, "R6 arrival order", int'(dma_req_sof), 100);
    take_and_finish();
    chk(stat_frame_cnt == 2 && stat_sof == 100, "R11 count two", int'(stat_frame_cnt), 2);
    stat_rd = 1;
    tick();
    stat_rd = 0;
    chk(stat_dma_frame == 0 && stat_frame_cnt == 0 && irq == 0, "R11 read clears",
        int'(stat_frame_cnt), 0);
    chk(dma_req_valid == 1 && dma_req_sof == 200, "R6 third frame", int'(dma_req_sof), 200);
    take_and_finish();
    chk(dma_req_valid == 0, "R13 queue empty", int'(dma_req_valid), 0);
    tick();
    store(50);
    chk(res_code == 2'b01 && dma_req_valid == 0 && isq_flush == 0, "R13 normal again",
        int'(dma_req_valid), 0);

    // commit holds off the switch
    do_reset();
    store(100);
    store(100);
    host_commit = 1; cfg_auto = 1; arr_da_pass = 1; arr_len = 9'd100; arr_valid = 1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(arr_ready == 0 && dma_req_valid == 0 && isq_flush == 0, "R8 held off",
          int'(dma_req_valid), 0);
      tick();
    end
    host_pop = 1;
    tick();
    host_pop = 0;
    host_commit = 0;
    #1;
    chk(arr_ready == 1, "R8 space after skip", int'(arr_ready), 1);
    tick();
    arr_valid = 0;
    chk(res_code == 2'b01 && isq_flush == 0 && dma_req_valid == 0, "R8 no switch",
        int'(isq_flush), 0);

    // DMA-only mode, interrupt gated by enable
    do_reset();
    cfg_dma_only = 1;
    #1;
    chk(isq_flush == 1, "R1 flush on DMA entry", int'(isq_flush), 1);
    tick();
    arr_len = 9'd10; arr_da_pass = 1; arr_valid = 1;
    tick();
    arr_valid = 0;
    chk(res_code == 2'b01, "R1 stored", int'(res_code), 1);
    chk(dma_req_valid == 1 && dma_req_len == 10, "R1 sent to DMA", int'(dma_req_len), 10);
    take_and_finish();
    chk(stat_dma_frame == 1 && irq == 0, "R10 irq disabled", int'(irq), 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule